// File: doc/BRIEF.md
# Vertical Sync and Field Flag Generator

This block drives the vertical sync (VS) and field (FIELD) pins of an interlaced standard-definition video output. It runs on the pixel clock and watches two strobes from the horizontal timing logic, one at the start of the horizontal sync pulse and one at its end, together with the current line number. From these it finds each line start and each mid-line point. At those points it raises or drops VS and toggles FIELD on lines chosen by software.

A parallel write port holds a pending copy of the settings. The pending copy is loaded into the working copy only at a line start, so a write made part-way through a line never disturbs that line. Each VS edge can be placed at the line start or at mid-line, and that choice is made separately for the odd field and the even field. The line-start reference can be the sync begin strobe or the sync end strobe. Both outputs have a polarity control. A fixed-timing mode ignores the programmed timing and uses built-in interlaced values.

Top module: `vsf_gen`

## Requirements
- R1: After reset, vs_o = 0 and field_o = 0. The settings reset to manual mode with the built-in timing values, non-inverted polarity and the line start at the sync end strobe.
- R2: When the selected start-of-line bit for an edge is 1, VS changes on the clock edge that samples the line-start strobe. The output is visible in the next cycle. VS rises on line vsb_line of the current field and falls on line vse_line of the current field.
- R3: When the start-of-line bit for an edge is 0, VS changes on the clock edge that samples the cycle lying total/2 cycles after the line-start strobe. The line used for the match is the line captured at that line start.
- R4: The odd field uses the odd line numbers and bits (ctrl bits 4 and 6, addresses 2 and 3). The even field uses the even ones (ctrl bits 5 and 7, addresses 4 and 5). The two fields are selected independently. VS rises only when it is low and falls only when it is high.
- R5: When ctrl bit 1 is 0, the line start is the hs_end_i strobe. When ctrl bit 1 is 1, the line start is the hs_begin_i strobe.
- R6: When ctrl bit 2 is 1, vs_o is inverted.
- R7: FIELD changes only at a line start. It becomes 1 (even) on line tog_even (address 6), or else 0 (odd) on line tog_odd (address 7). When ctrl bit 3 is 1, field_o is inverted. At a line start, the new field value selects which field's VS settings apply.
- R8: A write updates only the pending settings. These are loaded at the next line start and govern that line start and the rest of that line.
- R9: When ctrl bit 0 is 0 (fixed mode), the timing uses built-in values and ignores the written reference, line numbers, start-of-line bits and total. Polarity still follows ctrl bits 2 and 3.
- R10: The built-in values are: total 1716; odd field rises at mid-line of line 4 and falls at the start of line 7; even field rises at the start of line 266 and falls at mid-line of line 269; FIELD goes even on line 266 and odd on line 4; ctrl = 0x61.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_begin_i | input | 1 | One-cycle strobe at the start of horizontal sync |
| hs_end_i | input | 1 | One-cycle strobe at the end of horizontal sync |
| line_i | input | 10 | Current line number, valid with the strobes |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register address: 0 ctrl, 1 total samples, 2 to 5 VS lines (odd begin, odd end, even begin, even end), 6 even toggle line, 7 odd toggle line |
| wr_data_i | input | 11 | Write data. Ctrl bits: 0 manual, 1 reference is sync begin, 2 invert VS, 3 invert FIELD, 4 to 7 start-of-line for odd begin, even begin, odd end, even end |
| vs_o | output | 1 | Vertical sync output |
| field_o | output | 1 | Field flag output |

## Verification
The hardest case to reach is a write that lands between a line start and the mid-line point of that same line, where the old and new settings would disagree. The stimulus reaches it by writing, at a chosen pixel offset in line 2, a control word that moves the odd-field VS edge from mid-line to line start and inverts VS. The old mid-line edge must still occur, and the polarity must not change until line 3 begins. The stimulus also rewrites the total during a line, changes the reference while the old reference is still active, and steps through every combination of start-of-line bits, reference and polarity.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
  parameter int unsigned LINE_W = 10;
  parameter int unsigned PIX_W  = 11;
  parameter int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = (LINE_W > PIX_W) ? LINE_W : PIX_W;

  typedef struct packed {
    logic              vsb_ls_odd;
    logic              vsb_ls_even;
    logic              vse_ls_odd;
    logic              vse_ls_even;
    logic [LINE_W-1:0] vsb_odd;
    logic [LINE_W-1:0] vse_odd;
    logic [LINE_W-1:0] vsb_even;
    logic [LINE_W-1:0] vse_even;
    logic [LINE_W-1:0] tog_even;
    logic [LINE_W-1:0] tog_odd;
  } edge_t;

  typedef struct packed {
    logic             manual;
    logic             ref_hsb;
    logic             vs_inv;
    logic             fld_inv;
    logic [PIX_W-1:0] total;
    edge_t            edges;
  } cfg_t;

  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TOTAL    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_VSB_ODD  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_VSE_ODD  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_VSB_EVEN = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_VSE_EVEN = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_TOG_EVEN = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_TOG_ODD  = ADDR_W'(7);

  // built-in interlaced timing, also the reset value
  localparam cfg_t CFG_DEF = '{
    manual:  1'b1,
    ref_hsb: 1'b0,
    vs_inv:  1'b0,
    fld_inv: 1'b0,
    total:   PIX_W'(1716),
    edges: '{
      vsb_ls_odd:  1'b0,
      vsb_ls_even: 1'b1,
      vse_ls_odd:  1'b1,
      vse_ls_even: 1'b0,
      vsb_odd:     LINE_W'(4),
      vse_odd:     LINE_W'(7),
      vsb_even:    LINE_W'(266),
      vse_even:    LINE_W'(269),
      tog_even:    LINE_W'(266),
      tog_odd:     LINE_W'(4)
    }
  };
endpackage

// File: rtl/vsf_regs.sv
module vsf_regs
  import vsf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ls_ev_i,
  output logic              act_ref_hsb_o,
  output logic              act_vs_inv_o,
  output logic              act_fld_inv_o,
  output logic [PIX_W-1:0]  act_total_o,
  output edge_t             cur_edges_o
);
  cfg_t             shadow_q;
  logic             eff_ref, eff_vinv, eff_finv;
  logic [PIX_W-1:0] eff_total;
  edge_t            eff_edges;
  edge_t            act_edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= CFG_DEF;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL: begin
          shadow_q.manual            <= wr_data_i[0];
          shadow_q.ref_hsb           <= wr_data_i[1];
          shadow_q.vs_inv            <= wr_data_i[2];
          shadow_q.fld_inv           <= wr_data_i[3];
          shadow_q.edges.vsb_ls_odd  <= wr_data_i[4];
          shadow_q.edges.vsb_ls_even <= wr_data_i[5];
          shadow_q.edges.vse_ls_odd  <= wr_data_i[6];
          shadow_q.edges.vse_ls_even <= wr_data_i[7];
        end
        A_TOTAL:    shadow_q.total          <= wr_data_i[PIX_W-1:0];
        A_VSB_ODD:  shadow_q.edges.vsb_odd  <= wr_data_i[LINE_W-1:0];
        A_VSE_ODD:  shadow_q.edges.vse_odd  <= wr_data_i[LINE_W-1:0];
        A_VSB_EVEN: shadow_q.edges.vsb_even <= wr_data_i[LINE_W-1:0];
        A_VSE_EVEN: shadow_q.edges.vse_even <= wr_data_i[LINE_W-1:0];
        A_TOG_EVEN: shadow_q.edges.tog_even <= wr_data_i[LINE_W-1:0];
        default:    shadow_q.edges.tog_odd  <= wr_data_i[LINE_W-1:0];
      endcase
    end
  end

  // fixed mode keeps only the polarity bits from software
  always_comb begin
    if (shadow_q.manual) begin
      eff_ref   = shadow_q.ref_hsb;
      eff_total = shadow_q.total;
      eff_edges = shadow_q.edges;
    end else begin
      eff_ref   = CFG_DEF.ref_hsb;
      eff_total = CFG_DEF.total;
      eff_edges = CFG_DEF.edges;
    end
    eff_vinv = shadow_q.vs_inv;
    eff_finv = shadow_q.fld_inv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_ref_hsb_o <= CFG_DEF.ref_hsb;
      act_vs_inv_o  <= CFG_DEF.vs_inv;
      act_fld_inv_o <= CFG_DEF.fld_inv;
      act_total_o   <= CFG_DEF.total;
      act_edges_q   <= CFG_DEF.edges;
    end else if (ls_ev_i) begin
      act_ref_hsb_o <= eff_ref;
      act_vs_inv_o  <= eff_vinv;
      act_fld_inv_o <= eff_finv;
      act_total_o   <= eff_total;
      act_edges_q   <= eff_edges;
    end
  end

  // pending values already govern the line start that loads them
  assign cur_edges_o = ls_ev_i ? eff_edges : act_edges_q;

  // R8
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ls_ev_i |=> $stable({act_ref_hsb_o, act_vs_inv_o, act_fld_inv_o, act_total_o, act_edges_q}));
endmodule

// File: rtl/vsf_hpos.sv
module vsf_hpos
  import vsf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_begin_i,
  input  logic              hs_end_i,
  input  logic              ref_hsb_i,
  input  logic [PIX_W-1:0]  total_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              ls_ev_o,
  output logic              mid_ev_o,
  output logic [LINE_W-1:0] line_q_o
);
  localparam logic [PIX_W-1:0] CNT_MAX = '1;

  logic [PIX_W-1:0] hcnt_q;

  assign ls_ev_o  = ref_hsb_i ? hs_begin_i : hs_end_i;
  assign mid_ev_o = !ls_ev_o && (hcnt_q == (total_i >> 1));

  // hcnt_q = cycles since the last line start; parked at max before the first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q   <= CNT_MAX;
      line_q_o <= '0;
    end else if (ls_ev_o) begin
      hcnt_q   <= PIX_W'(1);
      line_q_o <= line_i;
    end else if (hcnt_q != CNT_MAX) begin
      hcnt_q <= hcnt_q + PIX_W'(1);
    end
  end

  // R3
  mid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_ev_o |=> !mid_ev_o);
endmodule

// File: rtl/vsf_core.sv
module vsf_core
  import vsf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ls_ev_i,
  input  logic              mid_ev_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] line_q_i,
  input  edge_t             edges_i,
  output logic              vs_q_o,
  output logic              field_q_o
);
  logic              fld_nx, vs_nx, fsel;
  logic [LINE_W-1:0] ln, b_line, e_line;
  logic              b_ls, e_ls, want_ls;

  always_comb begin
    fld_nx = field_q_o;
    if (ls_ev_i) begin
      if (line_i == edges_i.tog_even)     fld_nx = 1'b1;
      else if (line_i == edges_i.tog_odd) fld_nx = 1'b0;
    end
    fsel    = ls_ev_i ? fld_nx : field_q_o;
    ln      = ls_ev_i ? line_i : line_q_i;
    want_ls = ls_ev_i;
    b_line  = fsel ? edges_i.vsb_even    : edges_i.vsb_odd;
    e_line  = fsel ? edges_i.vse_even    : edges_i.vse_odd;
    b_ls    = fsel ? edges_i.vsb_ls_even : edges_i.vsb_ls_odd;
    e_ls    = fsel ? edges_i.vse_ls_even : edges_i.vse_ls_odd;
    vs_nx   = vs_q_o;
    if (ls_ev_i || mid_ev_i) begin
      if (!vs_q_o && (ln == b_line) && (b_ls == want_ls))      vs_nx = 1'b1;
      else if (vs_q_o && (ln == e_line) && (e_ls == want_ls))  vs_nx = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q_o    <= 1'b0;
      field_q_o <= 1'b0;
    end else begin
      vs_q_o    <= vs_nx;
      field_q_o <= fld_nx;
    end
  end

  // R2
  vs_edge_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ls_ev_i || mid_ev_i) |=> $stable(vs_q_o));
  // R7
  field_at_ls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ls_ev_i |=> $stable(field_q_o));
endmodule

// File: rtl/vsf_gen.sv
module vsf_gen
  import vsf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_begin_i,
  input  logic              hs_end_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              vs_o,
  output logic              field_o
);
  logic              ls_ev, mid_ev;
  logic              act_ref_hsb, act_vs_inv, act_fld_inv;
  logic [PIX_W-1:0]  act_total;
  edge_t             cur_edges;
  logic [LINE_W-1:0] line_q;
  logic              vs_q, field_q;

  vsf_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ls_ev_i      (ls_ev),
    .act_ref_hsb_o(act_ref_hsb),
    .act_vs_inv_o (act_vs_inv),
    .act_fld_inv_o(act_fld_inv),
    .act_total_o  (act_total),
    .cur_edges_o  (cur_edges)
  );

  vsf_hpos u_hpos (
    .clk_i, .rst_ni, .hs_begin_i, .hs_end_i,
    .ref_hsb_i(act_ref_hsb),
    .total_i  (act_total),
    .line_i,
    .ls_ev_o  (ls_ev),
    .mid_ev_o (mid_ev),
    .line_q_o (line_q)
  );

  vsf_core u_core (
    .clk_i, .rst_ni,
    .ls_ev_i  (ls_ev),
    .mid_ev_i (mid_ev),
    .line_i,
    .line_q_i (line_q),
    .edges_i  (cur_edges),
    .vs_q_o   (vs_q),
    .field_q_o(field_q)
  );

  assign vs_o    = vs_q ^ act_vs_inv;
  assign field_o = field_q ^ act_fld_inv;

  // R6
  vs_pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ls_ev && !mid_ev) |=> $stable(vs_o));
  // R7
  field_pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ls_ev |=> $stable(field_o));
endmodule

// File: tb/vsf_gen_tb_top.sv
`timescale 1ns/1ps
module vsf_gen_tb_top;
  localparam int HSW = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hs_begin_i = 1'b0, hs_end_i = 1'b0;
  logic [9:0]  line_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [10:0] wr_data_i = '0;
  logic        vs_o, field_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  vsf_gen dut_i (
    .clk_i, .rst_ni, .hs_begin_i, .hs_end_i, .line_i,
    .wr_en_i, .wr_addr_i, .wr_data_i, .vs_o, .field_o
  );

  typedef struct packed { logic vs; logic fd; logic [7:0] tag; } item_t;
  item_t exp_q[$];

  // model: pending (s_*) and working (a_*) settings
  logic [7:0]  s_ctrl;
  logic [10:0] s_tot;
  logic [9:0]  s_ln [6];
  logic        a_ref, a_vi, a_fi;
  logic [10:0] a_tot;
  logic [3:0]  a_ls;
  logic [9:0]  a_ln [6];
  logic        m_vs, m_fd;
  logic [10:0] m_h;
  logic [9:0]  m_lq;

  task automatic model_init();
    s_ctrl = 8'h61; s_tot = 11'd1716;  // R10 built-in values
    s_ln[0] = 10'd4; s_ln[1] = 10'd7; s_ln[2] = 10'd266;
    s_ln[3] = 10'd269; s_ln[4] = 10'd266; s_ln[5] = 10'd4;
    a_ref = 1'b0; a_vi = 1'b0; a_fi = 1'b0; a_tot = 11'd1716; a_ls = 4'b0110;
    for (int i = 0; i < 6; i++) a_ln[i] = s_ln[i];
    m_vs = 1'b0; m_fd = 1'b0; m_h = 11'h7ff; m_lq = '0;
  endtask

  task automatic model_step(input logic hsb, input logic hse, input logic [9:0] ln,
                            input logic wr, input logic [2:0] ad, input logic [10:0] dt,
                            input int tag);
    logic        e_ref, ls, fnx, bb, eb;
    logic [10:0] e_tot;
    logic [3:0]  e_ls;   // {vse_even, vse_odd, vsb_even, vsb_odd}
    logic [9:0]  e_ln [6];
    logic [9:0]  bl, el;
    if (s_ctrl[0]) begin
      e_ref = s_ctrl[1]; e_tot = s_tot; e_ls = {s_ctrl[7], s_ctrl[6], s_ctrl[5], s_ctrl[4]};
      for (int i = 0; i < 6; i++) e_ln[i] = s_ln[i];
    end else begin  // R9 fixed values
      e_ref = 1'b0; e_tot = 11'd1716; e_ls = 4'b0110;
      e_ln[0] = 10'd4; e_ln[1] = 10'd7; e_ln[2] = 10'd266;
      e_ln[3] = 10'd269; e_ln[4] = 10'd266; e_ln[5] = 10'd4;
    end
    ls = a_ref ? hsb : hse;
    if (ls) begin
      fnx = (ln == e_ln[4]) ? 1'b1 : (ln == e_ln[5]) ? 1'b0 : m_fd;
      bl = fnx ? e_ln[2] : e_ln[0]; el = fnx ? e_ln[3] : e_ln[1];
      bb = fnx ? e_ls[1] : e_ls[0]; eb = fnx ? e_ls[3] : e_ls[2];
      if (!m_vs && ln == bl && bb) m_vs = 1'b1;
      else if (m_vs && ln == el && eb) m_vs = 1'b0;
      m_fd = fnx; m_h = 11'd1; m_lq = ln;
      a_ref = e_ref; a_vi = s_ctrl[2]; a_fi = s_ctrl[3]; a_tot = e_tot; a_ls = e_ls;
      for (int i = 0; i < 6; i++) a_ln[i] = e_ln[i];
    end else begin
      if (m_h == (a_tot >> 1)) begin
        bl = m_fd ? a_ln[2] : a_ln[0]; el = m_fd ? a_ln[3] : a_ln[1];
        bb = m_fd ? a_ls[1] : a_ls[0]; eb = m_fd ? a_ls[3] : a_ls[2];
        if (!m_vs && m_lq == bl && !bb) m_vs = 1'b1;
        else if (m_vs && m_lq == el && !eb) m_vs = 1'b0;
      end
      if (m_h != 11'h7ff) m_h = m_h + 11'd1;
    end
    if (wr) begin
      if (ad == 3'd0) s_ctrl = dt[7:0];
      else if (ad == 3'd1) s_tot = dt;
      else s_ln[ad - 3'd2] = dt[9:0];
    end
    exp_q.push_back('{vs: m_vs ^ a_vi, fd: m_fd ^ a_fi, tag: 8'(tag)});
  endtask

  task automatic cyc(input logic hsb, input logic hse, input logic [9:0] ln,
                     input logic wr, input logic [2:0] ad, input logic [10:0] dt, input int tag);
    @(negedge clk_i);
    hs_begin_i = hsb; hs_end_i = hse; line_i = ln;
    wr_en_i = wr; wr_addr_i = ad; wr_data_i = dt;
    model_step(hsb, hse, ln, wr, ad, dt, tag);
  endtask

  task automatic drive_line(input int ln, input int len, input int tag,
                            input int wk = -1, input logic [2:0] ad = '0, input logic [10:0] dt = '0);
    for (int k = 0; k < len; k++)
      cyc(k == 0, k == HSW, 10'(ln), k == wk, ad, dt, tag);
  endtask

  task automatic wr(input logic [2:0] ad, input logic [10:0] dt, input int tag);
    cyc(1'b0, 1'b0, 10'd0, 1'b1, ad, dt, tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: pops one expected item per clock
  initial begin
    item_t it;
    @(posedge rst_ni);
    forever begin
      @(posedge clk_i);
      #5;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        checks++;
        if (vs_o !== it.vs || field_o !== it.fd) begin
          errors++;
          if (errors <= 20)
            $display("FAIL R%0d t=%0t vs_o=%b field_o=%b expected vs=%b field=%b",
                     it.tag, $time, vs_o, field_o, it.vs, it.fd);
        end
      end
    end
  end

  initial begin
    #(3800000);
    errors++; checks++;
    $display("FAIL watchdog expired, expected end of stimulus");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] ctrl;
    int tag;
    model_init();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    checks++;
    if (vs_o !== 1'b0 || field_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 vs_o=%b field_o=%b expected 0 0", vs_o, field_o);
    end
    rst_ni = 1'b1;

    // R10 built-in timing from reset values, both fields
    for (int ln = 262; ln <= 272; ln++) drive_line(ln, 1720, 10);
    for (int ln = 1; ln <= 9; ln++) drive_line(ln, 1720, 10);

    // R9 fixed mode: written reference, line and total must not matter
    wr(3'd0, 11'h002, 9);
    wr(3'd2, 11'd5, 9);
    wr(3'd1, 11'd16, 9);
    for (int ln = 2; ln <= 8; ln++) drive_line(ln, 1720, 9);
    for (int ln = 264; ln <= 270; ln++) drive_line(ln, 1720, 9);

    // short manual timing: total 16, VS odd 2..3, even 7..8, toggles 6/1
    wr(3'd2, 11'd2, 4); wr(3'd3, 11'd3, 4); wr(3'd4, 11'd7, 4);
    wr(3'd5, 11'd8, 4); wr(3'd6, 11'd6, 4); wr(3'd7, 11'd1, 4);
    for (int c = 0; c < 128; c++) begin
      ctrl = {c[3:0], c[6], c[5], c[4], 1'b1};
      if (c[5])              tag = 6;  // R6 VS inverted
      else if (c[6])         tag = 7;  // R7 FIELD inverted
      else if (c[4])         tag = 5;  // R5 reference at sync begin
      else if (c[3:0] == 4'hf) tag = 2;  // R2 all edges at line start
      else if (c[3:0] == 4'h0) tag = 3;  // R3 all edges at mid-line
      else                   tag = 4;  // R4 mixed per-field selection
      wr(3'd0, {3'b000, ctrl}, tag);
      if (c == 0) wr(3'd1, 11'd16, tag);
      for (int ln = 1; ln <= 10; ln++) drive_line(ln, 24, tag);
    end

    // R8 writes between line start and mid-line wait for next line start
    wr(3'd0, 11'h001, 8);
    drive_line(1, 24, 8);
    drive_line(2, 24, 8, 6, 3'd0, 11'h015);
    drive_line(3, 24, 8);
    drive_line(4, 24, 8);
    drive_line(5, 24, 8);
    wr(3'd0, 11'h001, 8);
    drive_line(6, 24, 8);
    drive_line(7, 48, 8, 6, 3'd1, 11'd40);
    drive_line(8, 48, 8);
    drive_line(1, 48, 8);
    drive_line(2, 48, 8);
    drive_line(3, 48, 8);

    repeat (4) @(negedge clk_i);
    summary();
    $finish;
  end
endmodule